// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block is the coherence engine for one private cache that sits on a shared, broadcast snooping bus. It keeps a tag and a four-state coherence code (invalid, shared-clean, exclusive-clean, modified-dirty) for every line of a small direct-mapped store. It serves processor loads and stores. When a request needs the bus, it raises a read, a read-for-ownership or a writeback. It also watches every transaction that other caches place on the bus and answers with a shared indication and, for dirty data, a flush.

The processor holds its request until `cpu_done` pulses. While a bus transaction is outstanding, `cpu_busy` stays high. The bus side is a single-pulse handshake: the controller holds `bus_req`, `bus_op` and `bus_addr` until the environment pulses `bus_ack`. That pulse means the transaction was granted and completed, and `bus_shared_in` is sampled in the same cycle. Data movement, arbitration and memory are outside the block.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset, every line is invalid. `bus_req`, `bus_op`, `cpu_busy`, `cpu_done`, `snp_shared` and `snp_flush` are all zero.
- R2: A read miss fills the line exclusive-clean when `bus_shared_in` is low in the `bus_ack` cycle, and shared-clean when it is high.
- R3: A store to an exclusive-clean line makes it modified with no bus request, and `cpu_done` pulses one cycle after the request is sampled.
- R4: A store to an invalid or shared line first issues a read-for-ownership. The line becomes modified when that transaction completes.
- R5: A load that hits any valid line, or a store that hits a modified line, completes locally. `cpu_done` pulses one cycle after the request is sampled, and there is no bus request.
- R6: A snooped read that hits a valid line leaves it shared-clean and asserts `snp_shared` one cycle later. `snp_flush` is also asserted if the line was modified.
- R7: A snooped read-for-ownership that hits a valid line invalidates it and does not assert `snp_shared`. It asserts `snp_flush` if the line was modified.
- R8: A snooped transaction whose tag does not match, which finds the line invalid, or which is a writeback gives no response and changes no state.
- R9: A miss whose victim line is modified issues a writeback of the victim (address = victim tag and index) before the fill. Shared or exclusive victims are dropped without any bus transaction.
- R10: When a snoop and a processor request arrive in the same cycle, the snoop updates the line first. The request is then evaluated against the updated state.
- R11: From the cycle after a miss is accepted until `cpu_done`, `cpu_busy` is high. `bus_req` is held with stable `bus_op` and `bus_addr` until `bus_ack`.
- R12: The bus operation codes are 0 for idle, 1 for read, 2 for read-for-ownership and 3 for writeback. A bus address is {tag, index}, where the index is the low IDX_W bits.
- R13: If a snoop removes the dirty data of a victim while its writeback is still waiting, the writeback is withdrawn. The fill is requested in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Line address {tag, index} |
| cpu_busy | output | 1 | Request is waiting on the bus |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transaction pending |
| bus_op | output | 2 | Operation code (R12) |
| bus_addr | output | ADDR_W | Transaction line address |
| bus_ack | input | 1 | Transaction granted and completed this cycle |
| bus_shared_in | input | 1 | Another cache holds the line, valid with bus_ack |
| snp_valid | input | 1 | A transaction from another cache is on the bus |
| snp_op | input | 2 | Snooped operation code (R12) |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the snooped line (read) |
| snp_flush | output | 1 | This cache supplies dirty data |

## Verification
The bench checks states only through the ports. It shows an exclusive line by a store that completes with no bus traffic, a shared line by a store that needs a read-for-ownership, and a modified line by a snoop that flushes. The riskiest cases are a snoop arriving in the same cycle as a store to an exclusive line, and a snoop that takes away a victim's dirty data while its writeback waits. A controller that ordered the first case wrongly would let the store finish silently next to a new sharer. One that ignored the second would write back a line it no longer owns. Conflict eviction checks that modified victims go out ahead of the fill and clean ones leave silently. A stalled grant checks that busy and the bus request are held.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BOP_NONE = 2'd0,
    BOP_RD   = 2'd1,
    BOP_RDX  = 2'd2,
    BOP_WB   = 2'd3
  } bus_op_t;
endpackage

// File: rtl/mesi_snoop_eval.sv
module mesi_snoop_eval
  import mesi_pkg::*;
(
  input  logic       snp_valid,
  input  logic [1:0] snp_op,
  input  line_st_t   cur_st,
  input  logic       tag_eq,
  output logic       hit,
  output line_st_t   nxt_st,
  output logic       want_shared,
  output logic       want_flush
);
  logic is_rd, is_rdx;

  always_comb begin
    is_rd       = (snp_op == BOP_RD);
    is_rdx      = (snp_op == BOP_RDX);
    hit         = snp_valid && tag_eq && (cur_st != LS_INV) && (is_rd || is_rdx);
    nxt_st      = cur_st;
    if (hit) nxt_st = is_rdx ? LS_INV : LS_SHR;
    want_shared = hit && is_rd;
    want_flush  = hit && (cur_st == LS_MOD);
  end
endmodule

// File: rtl/mesi_req_eval.sv
module mesi_req_eval
  import mesi_pkg::*;
(
  input  logic       we,
  input  line_st_t   st,
  input  logic       tag_eq,
  output logic       local_ok,
  output line_st_t   local_st,
  output logic [1:0] need_op,
  output logic       evict_wb
);
  logic hit;

  always_comb begin
    hit      = (st != LS_INV) && tag_eq;
    local_ok = hit && (!we || st == LS_EXC || st == LS_MOD);
    local_st = we ? LS_MOD : st;
    need_op  = we ? BOP_RDX : BOP_RD;
    evict_wb = !tag_eq && (st == LS_MOD);
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {PH_IDLE, PH_WB, PH_FILL} phase_t;

  line_st_t          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  phase_t            phase_q;
  logic [TAG_W-1:0]  req_tag_q;
  logic [IDX_W-1:0]  req_idx_q;
  logic              req_we_q;

  // snoop side lookup
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  logic             s_hit, s_shr, s_fl;
  line_st_t         s_nst;

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  mesi_snoop_eval u_snp (
    .snp_valid  (snp_valid),
    .snp_op     (snp_op),
    .cur_st     (st_q[s_idx]),
    .tag_eq     (tag_q[s_idx] == s_tag),
    .hit        (s_hit),
    .nxt_st     (s_nst),
    .want_shared(s_shr),
    .want_flush (s_fl)
  );

  // processor side lookup, seen after the snoop of the same cycle
  logic [IDX_W-1:0] l_idx;
  logic [TAG_W-1:0] l_tag;
  logic             l_we;
  line_st_t         l_st;
  logic             loc_ok, evict_wb;
  line_st_t         loc_st;
  logic [1:0]       need_op;

  always_comb begin
    if (phase_q == PH_IDLE) begin
      l_idx = cpu_addr[IDX_W-1:0];
      l_tag = cpu_addr[ADDR_W-1:IDX_W];
      l_we  = cpu_we;
    end else begin
      l_idx = req_idx_q;
      l_tag = req_tag_q;
      l_we  = req_we_q;
    end
    l_st = (s_hit && s_idx == l_idx) ? s_nst : st_q[l_idx];
  end

  mesi_req_eval u_req (
    .we      (l_we),
    .st      (l_st),
    .tag_eq  (tag_q[l_idx] == l_tag),
    .local_ok(loc_ok),
    .local_st(loc_st),
    .need_op (need_op),
    .evict_wb(evict_wb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
      phase_q    <= PH_IDLE;
      req_tag_q  <= '0;
      req_idx_q  <= '0;
      req_we_q   <= 1'b0;
      cpu_busy   <= 1'b0;
      cpu_done   <= 1'b0;
      bus_req    <= 1'b0;
      bus_op     <= BOP_NONE;
      bus_addr   <= '0;
      snp_shared <= 1'b0;
      snp_flush  <= 1'b0;
    end else begin
      cpu_done   <= 1'b0;
      snp_shared <= s_shr;
      snp_flush  <= s_fl;
      if (s_hit) st_q[s_idx] <= s_nst;
      unique case (phase_q)
        PH_IDLE: if (cpu_req) begin
          if (loc_ok) begin
            st_q[l_idx] <= loc_st;
            cpu_done    <= 1'b1;
          end else begin
            req_tag_q <= l_tag;
            req_idx_q <= l_idx;
            req_we_q  <= l_we;
            cpu_busy  <= 1'b1;
            bus_req   <= 1'b1;
            if (evict_wb) begin
              phase_q  <= PH_WB;
              bus_op   <= BOP_WB;
              bus_addr <= {tag_q[l_idx], l_idx};
            end else begin
              phase_q  <= PH_FILL;
              bus_op   <= need_op;
              bus_addr <= {l_tag, l_idx};
            end
          end
        end
        PH_WB: if (bus_ack || l_st != LS_MOD) begin
          phase_q  <= PH_FILL;
          bus_op   <= need_op;
          bus_addr <= {req_tag_q, req_idx_q};
        end
        PH_FILL: if (bus_ack) begin
          st_q[req_idx_q]  <= req_we_q ? LS_MOD : (bus_shared_in ? LS_SHR : LS_EXC);
          tag_q[req_idx_q] <= req_tag_q;
          phase_q  <= PH_IDLE;
          bus_req  <= 1'b0;
          bus_op   <= BOP_NONE;
          cpu_busy <= 1'b0;
          cpu_done <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_snoop_chk.sv
module mesi_snoop_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_busy,
  input logic              cpu_done,
  input logic              bus_req,
  input logic [1:0]        bus_op,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              snp_valid,
  input logic [1:0]        snp_op,
  input logic              snp_shared,
  input logic              snp_flush
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bus_req && !cpu_busy && !cpu_done && !snp_shared && !snp_flush));

  // R6
  shared_cause_chk: assert property (@(posedge clk) disable iff (rst)
    snp_shared |-> $past(snp_valid && snp_op == 2'd1));

  // R7
  flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    snp_flush |-> $past(snp_valid && (snp_op == 2'd1 || snp_op == 2'd2)));

  // R9
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_op == 2'd3 && bus_ack) |=> (bus_req && (bus_op == 2'd1 || bus_op == 2'd2)));

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && bus_op != 2'd3) |=> (bus_req && $stable(bus_op) && $stable(bus_addr)));

  // R11
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> cpu_busy);

  // R5
  done_free_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> (!cpu_busy && !bus_req));
endmodule

bind mesi_snoop_ctrl mesi_snoop_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_busy  (cpu_busy),
  .cpu_done  (cpu_done),
  .bus_req   (bus_req),
  .bus_op    (bus_op),
  .bus_addr  (bus_addr),
  .bus_ack   (bus_ack),
  .snp_valid (snp_valid),
  .snp_op    (snp_op),
  .snp_shared(snp_shared),
  .snp_flush (snp_flush)
);

// File: tb/sim_mesi_snoop_ctrl.sv
module sim_mesi_snoop_ctrl;
  localparam int AW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_busy, cpu_done, bus_req;
  logic [1:0]    bus_op;
  logic [AW-1:0] bus_addr;
  logic          bus_ack = 0, bus_shared_in = 0;
  logic          snp_valid = 0;
  logic [1:0]    snp_op = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_shared, snp_flush;

  mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .bus_req(bus_req), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_flush(snp_flush)
  );

  int n_vec = 0;
  int n_bad = 0;
  int n_tx;
  int tx_op [4];
  int tx_addr [4];
  int acc_cyc;
  bit busy_ok;

  task automatic chk(input string rq, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // bus and memory model: acks each transaction after lat waiting cycles
  task automatic service(input bit shr, input int lat);
    int wait_cnt = 0;
    n_tx = 0; acc_cyc = 0; busy_ok = 1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      acc_cyc++;
      if (cpu_done) begin
        cpu_req = 0; bus_ack = 0; bus_shared_in = 0;
        return;
      end
      if (!cpu_busy) busy_ok = 0;
      if (bus_req) begin
        if (wait_cnt == lat) begin
          if (n_tx < 4) begin tx_op[n_tx] = bus_op; tx_addr[n_tx] = bus_addr; end
          n_tx++; bus_ack = 1; bus_shared_in = shr; wait_cnt = 0;
        end else begin
          bus_ack = 0; wait_cnt++;
        end
      end else bus_ack = 0;
    end
    chk("access timeout", 0, 1);
    cpu_req = 0; bus_ack = 0;
  endtask

  task automatic access(input bit we, input int addr, input bit shr, input int lat);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr[AW-1:0];
    service(shr, lat);
  endtask

  task automatic snoop(input int op, input int addr, input bit e_sh, input bit e_fl, input string rq);
    @(negedge clk);
    snp_valid = 1; snp_op = op[1:0]; snp_addr = addr[AW-1:0];
    @(negedge clk);
    chk({rq, " snoop shared"}, snp_shared, e_sh);
    chk({rq, " snoop flush"}, snp_flush, e_fl);
    snp_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 bus_req", bus_req, 0);
    chk("R1 bus_op", bus_op, 0);
    chk("R1 busy", cpu_busy, 0);
    chk("R1 done", cpu_done, 0);
    chk("R1 shared", snp_shared, 0);
    chk("R1 flush", snp_flush, 0);
    access(0, 'h04, 0, 0);  // R1 line starts invalid, R12 read code 1
    chk("R1 miss tx", n_tx, 1);
    chk("R12 rd op", tx_op[0], 1);
    chk("R12 rd addr", tx_addr[0], 'h04);
  endtask

  task automatic t_exclusive_write;
    access(1, 'h04, 0, 0);  // R3 E -> M silent
    chk("R3 no tx", n_tx, 0);
    chk("R3 cycles", acc_cyc, 1);
    snoop(1, 'h04, 1, 1, "R6 M");
    access(0, 'h04, 0, 0);  // R5 load hits shared
    chk("R5 no tx", n_tx, 0);
    chk("R5 cycles", acc_cyc, 1);
    access(1, 'h04, 0, 0);  // R4 store to shared
    chk("R4 tx", n_tx, 1);
    chk("R4 rdx op", tx_op[0], 2);
    access(1, 'h04, 0, 0);  // R5 store hits modified
    chk("R5 M store no tx", n_tx, 0);
    snoop(2, 'h04, 0, 1, "R7 M");
    access(0, 'h04, 0, 0);  // R7 line now invalid
    chk("R7 refetch", n_tx, 1);
  endtask

  task automatic t_shared_fill;
    access(0, 'h09, 1, 0);  // R2 shared_in high -> S
    chk("R2 fill tx", n_tx, 1);
    access(1, 'h09, 0, 0);
    chk("R2 S needs rdx", n_tx, 1);
    chk("R2 S rdx op", tx_op[0], 2);
  endtask

  task automatic t_snoop_exclusive;
    access(0, 'h0A, 0, 0);
    snoop(1, 'h0A, 1, 0, "R6 E");
    access(1, 'h0A, 0, 0);
    chk("R6 E became S", n_tx, 1);
    chk("R6 rdx op", tx_op[0], 2);
  endtask

  task automatic t_snoop_ignored;
    snoop(1, 'h4A, 0, 0, "R8 tag miss");
    snoop(3, 'h0A, 0, 0, "R8 writeback");
    snoop(2, 'h8A, 0, 0, "R8 rdx tag miss");
    snoop(1, 'h03, 0, 0, "R8 invalid line");
    access(1, 'h0A, 0, 0);
    chk("R8 still M", n_tx, 0);
  endtask

  task automatic t_evict;
    access(0, 'h4A, 0, 0);  // victim 0x0A is M
    chk("R9 two tx", n_tx, 2);
    chk("R9 wb op", tx_op[0], 3);
    chk("R9 wb addr", tx_addr[0], 'h0A);
    chk("R9 fill op", tx_op[1], 1);
    chk("R9 fill addr", tx_addr[1], 'h4A);
    access(0, 'h8A, 1, 0);  // E victim
    chk("R9 silent E", n_tx, 1);
    access(0, 'hCA, 0, 0);  // S victim
    chk("R9 silent S", n_tx, 1);
  endtask

  task automatic t_stall;
    access(1, 'h03, 0, 3);
    chk("R11 cycles", acc_cyc, 5);
    chk("R11 busy held", busy_ok, 1);
    chk("R11 one tx", n_tx, 1);
    chk("R11 rdx addr", tx_addr[0], 'h03);
  endtask

  task automatic t_same_cycle;
    access(0, 'h05, 0, 0);  // now E
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 'h05;
    snp_valid = 1; snp_op = 2'd1; snp_addr = 'h05;
    @(negedge clk);
    snp_valid = 0;
    chk("R10 shared", snp_shared, 1);
    chk("R10 no flush", snp_flush, 0);
    chk("R10 not local", cpu_done, 0);
    chk("R10 bus_req", bus_req, 1);
    chk("R10 rdx", bus_op, 2);
    bus_ack = 1;
    @(negedge clk);
    bus_ack = 0;
    chk("R10 done", cpu_done, 1);
    cpu_req = 0;
    snoop(1, 'h05, 1, 1, "R10 now M");
  endtask

  task automatic t_wb_cancel;
    access(1, 'h06, 0, 0);  // M at index 2
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 'h46;
    @(negedge clk);
    chk("R13 wb op", bus_op, 3);
    chk("R13 wb addr", bus_addr, 'h06);
    snp_valid = 1; snp_op = 2'd2; snp_addr = 'h06;
    @(negedge clk);
    snp_valid = 0;
    chk("R13 flush", snp_flush, 1);
    chk("R13 fill op", bus_op, 1);
    chk("R13 fill addr", bus_addr, 'h46);
    bus_ack = 1; bus_shared_in = 0;
    @(negedge clk);
    bus_ack = 0;
    chk("R13 done", cpu_done, 1);
    cpu_req = 0;
    access(1, 'h46, 0, 0);
    chk("R13 filled E", n_tx, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_exclusive_write();
    t_shared_fill();
    t_snoop_exclusive();
    t_snoop_ignored();
    t_evict();
    t_stall();
    t_same_cycle();
    t_wb_cancel();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule